// File: doc/BRIEF.md
# Fractional Clock Source Divider

This block picks one of several source clock strobes, all of them single-cycle enables in one fast fabric clock, and divides it by a fixed-point ratio to produce an output clock-enable strobe. The choice of source and an on/off control come from a control word. The divisor comes from a separate divider word. The divisor is a fixed-point number: its integer part always starts at bit 12, and its fraction sits directly below that bit. The widths of both parts are instance parameters.

Division uses a first-order phase accumulator. Each selected source strobe adds one unit (2^F) to the accumulator. When the accumulator reaches the divisor, the block emits an output strobe and takes the divisor off the accumulator. Over time the average output rate is source × 2^F / divisor. An instance built with zero integer bits and zero fraction bits has no accumulator, and it forwards the selected source unchanged. A busy flag follows the enable so that software can see whether the output is running.

Top module: `fclk_div_mux`

## Requirements
- R1: `ctl_i[3:0]` selects the source. Code 0 is ground and never yields an output strobe. Strobes on sources that are not selected have no effect.
- R2: `ctl_i[4]` is the enable. While it is 0, `clk_en_o` stays low and the accumulator phase is held, so counting resumes from the same phase once the enable returns to 1.
- R3: `busy_o` equals the enable bit of `ctl_i`, one clock later. It is 0 out of reset.
- R4: Every output strobe is high for exactly one cycle. It occurs in the cycle after the selected source strobe was sampled, and one source strobe gives at most one output strobe.
- R5: The divisor D is `div_i[12+I-1 : 12-F]`. Starting from a cleared accumulator with D ≥ 2^F, N selected strobes give floor(N·2^F/D) output strobes.
- R6: When D = 0, the divided output stays stopped.
- R7: When 0 < D < 2^F, every selected strobe gives one output strobe.
- R8: With I = F = 0, every selected, enabled strobe is passed through, and `div_i` is ignored.
- R9: After the source select or D changes, the next selected and enabled strobe clears the accumulator and gives no output strobe.
- R10: After reset, `clk_en_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_i | input | 32 | Control word: source select [3:0], enable [4] |
| div_i | input | 32 | Divider word, fixed point with the integer part starting at bit 12 |
| src_stb_i | input | NUM_SRC | Per-source clock strobes |
| clk_en_o | output | 1 | Divided output strobe |
| busy_o | output | 1 | Mirror of the enable |

## Verification
The bench builds two instances that share their inputs. The main instance uses NUM_SRC = 4, I = 4 and F = 2, so one unit is 4 and divisors such as 2.5 or 15.75 fall into short strobe trains whose output counts can be worked out by hand. The second instance uses I = F = 0, which exercises the pass-through variant against the same stimulus. In particular, when D = 0 the main instance is silent while the pass-through instance is still running. Because the fraction is small, an accumulator residue of a known size is easy to set up. That residue makes the clear after a configuration change, and the phase hold while disabled, show up as a shift in which strobe produces the output.

// File: rtl/fclk_pkg.sv
package fclk_pkg;
  localparam int unsigned SRC_W     = 4;
  localparam int unsigned MAX_SRC   = 1 << SRC_W;
  localparam int unsigned CTL_EN    = 4;
  localparam int unsigned DIV_POINT = 12;
endpackage

// File: rtl/fclk_src_sel.sv
module fclk_src_sel
  import fclk_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic [NUM_SRC-1:0] src_stb_i,
  input  logic [SRC_W-1:0]   sel_i,
  output logic               stb_o
);
  logic [MAX_SRC-1:0] pad;

  for (genvar g = 0; g < MAX_SRC; g++) begin : g_pad
    if (g == 0 || g >= NUM_SRC) begin : g_gnd
      assign pad[g] = 1'b0;
    end else begin : g_src
      assign pad[g] = src_stb_i[g];
    end
  end

  assign stb_o = pad[sel_i];

  logic unused_src0;
  assign unused_src0 = src_stb_i[0];
endmodule

// File: rtl/fclk_phase_acc.sv
module fclk_phase_acc #(
  parameter int unsigned DIV_W  = 24,
  parameter int unsigned FRAC_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic             run_i,
  input  logic             chg_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int unsigned AW = DIV_W + 1;
  localparam logic [AW-1:0] ONE = AW'(1) << FRAC_W;

  logic [AW-1:0] acc_q, sum, dext;
  logic          pend_q, tick_q;

  assign dext = {1'b0, div_i};
  assign sum  = acc_q + ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (stb_i && run_i) begin
        if (pend_q) begin
          acc_q <= '0;
        end else if (dext <= ONE) begin
          // ratio at or above one: one tick per strobe
          tick_q <= 1'b1;
          acc_q  <= '0;
        end else if (sum >= dext) begin
          tick_q <= 1'b1;
          acc_q  <= sum - dext;
        end else begin
          acc_q <= sum;
        end
      end
      if (chg_i) pend_q <= 1'b1;
      else if (stb_i && run_i) pend_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  assert_acc_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && dext > ONE) |-> (acc_q < dext));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && stb_i && run_i && !chg_i) |=> (acc_q == '0 && !tick_o));

  assert_small_div_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && stb_i && run_i && dext <= ONE) |=> tick_o);
endmodule

// File: rtl/fclk_div_mux.sv
module fclk_div_mux
  import fclk_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned INT_W   = 12,
  parameter int unsigned FRAC_W  = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [31:0]        ctl_i,
  input  logic [31:0]        div_i,
  input  logic [NUM_SRC-1:0] src_stb_i,
  output logic               clk_en_o,
  output logic               busy_o
);
  localparam int unsigned DIV_W   = INT_W + FRAC_W;
  localparam bit          BYPASS  = (DIV_W == 0);
  localparam int unsigned DW      = BYPASS ? 1 : DIV_W;
  localparam int unsigned DIV_LSB = DIV_POINT - FRAC_W;

  logic [SRC_W-1:0] src_q;
  logic             en_q;
  logic [DW-1:0]    div_q, div_in;
  logic             chg, sel_stb, out;

  assign div_in = BYPASS ? '0 : div_i[DIV_LSB +: DW];
  assign chg    = (ctl_i[SRC_W-1:0] != src_q) || (div_in != div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      en_q  <= 1'b0;
      div_q <= '0;
    end else begin
      src_q <= ctl_i[SRC_W-1:0];
      en_q  <= ctl_i[CTL_EN];
      div_q <= div_in;
    end
  end

  fclk_src_sel #(.NUM_SRC(NUM_SRC)) i_sel (
    .src_stb_i(src_stb_i),
    .sel_i    (src_q),
    .stb_o    (sel_stb)
  );

  if (BYPASS) begin : g_bypass
    logic pass_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pass_q <= 1'b0;
      else         pass_q <= sel_stb && en_q;
    end
    assign out = pass_q;

    assert_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_stb && en_q) |=> clk_en_o);
  end else begin : g_divide
    fclk_phase_acc #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) i_acc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .stb_i (sel_stb),
      .run_i (en_q && (div_q != '0)),
      .chg_i (chg),
      .div_i (div_q),
      .tick_o(out)
    );

    assert_zero_div_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_q == '0) |=> !clk_en_o);
  end

  assign clk_en_o = out;
  assign busy_o   = en_q;

  logic unused_bits;
  assign unused_bits = ^{ctl_i, div_i};

  assert_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i[CTL_EN] |=> busy_o);

  assert_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !clk_en_o);

  assert_ground_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_q == '0) |=> !clk_en_o);

  assert_one_shot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_stb |=> !clk_en_o);
endmodule

// File: tb/test_fclk_div_mux.sv
`timescale 1ns/1ps
module test_fclk_div_mux;
  localparam int unsigned NS = 4;
  localparam int unsigned F  = 2;
  localparam int unsigned U  = 1 << F;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [31:0]   ctl_i = '0;
  logic [31:0]   div_i = '0;
  logic [NS-1:0] src_stb_i = '0;
  logic          clk_en_o, busy_o, byp_en, byp_busy;

  int n_chk = 0, n_bad = 0, got_m = 0, got_b = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  fclk_div_mux #(.NUM_SRC(NS), .INT_W(4), .FRAC_W(F)) i_fclk_div_mux (
    .clk_i, .rst_ni, .ctl_i, .div_i, .src_stb_i, .clk_en_o, .busy_o);

  fclk_div_mux #(.NUM_SRC(NS), .INT_W(0), .FRAC_W(0)) i_fclk_div_mux_byp (
    .clk_i, .rst_ni, .ctl_i, .div_i, .src_stb_i,
    .clk_en_o(byp_en), .busy_o(byp_busy));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // divisor d in units of 2^-F, placed with its integer part at bit 12
  task automatic set_cfg(input int src, input bit en, input int d);
    @(negedge clk_i);
    ctl_i = {27'b0, en, 4'(src)};
    div_i = 32'(d) << (12 - F);
    @(negedge clk_i);
  endtask

  task automatic pulse(input int src);
    @(negedge clk_i);
    src_stb_i = NS'(1) << src;
    @(negedge clk_i);
    src_stb_i = '0;
    got_m = int'(clk_en_o);
    got_b = int'(byp_en);
  endtask

  task automatic train(input int src, input int n, output int cm, output int cb);
    cm = 0; cb = 0;
    for (int k = 0; k < n; k++) begin
      pulse(src);
      cm += got_m;
      cb += got_b;
    end
  endtask

  task automatic t_reset;
    chk("R10 clk_en_o", int'(clk_en_o), 0);
    chk("R10 busy_o", int'(busy_o), 0);
    chk("R10 bypass clk_en_o", int'(byp_en), 0);
  endtask

  task automatic t_busy;
    set_cfg(1, 1'b1, 10);
    chk("R3 busy on", int'(busy_o), 1);
    set_cfg(1, 1'b0, 10);
    chk("R3 busy off", int'(busy_o), 0);
    @(negedge clk_i); ctl_i = 32'h10;
    @(negedge clk_i);
    chk("R3 busy follows enable", int'(busy_o), 1);
  endtask

  task automatic t_ratio(input int d, input int n);
    int cm, cb;
    set_cfg(1, 1'b1, d);
    pulse(1);
    chk("R9 primer silent", got_m, 0);
    train(1, n, cm, cb);
    chk($sformatf("R5 count d=%0d", d), cm, (n * U) / d);
    chk("R8 bypass passes all", cb, n);
  endtask

  task automatic t_width;
    set_cfg(2, 1'b1, U);
    pulse(2);
    pulse(2);
    chk("R4 strobe high", got_m, 1);
    @(negedge clk_i);
    chk("R4 strobe one cycle", int'(clk_en_o), 0);
    chk("R4 bypass one cycle", int'(byp_en), 0);
  endtask

  task automatic t_clear;
    int cm, cb;
    set_cfg(1, 1'b1, 10);
    pulse(1);
    train(1, 3, cm, cb);           // acc 4,8,12->2 : one output, residue 2
    chk("R5 residue setup", cm, 1);
    set_cfg(1, 1'b1, 12);
    pulse(1); chk("R9 clear strobe", got_m, 0);
    pulse(1); chk("R9 after clear 1", got_m, 0);
    pulse(1); chk("R9 after clear 2", got_m, 0);
    pulse(1); chk("R9 after clear 3", got_m, 1);
    set_cfg(2, 1'b1, 12);
    pulse(2); chk("R9 source change clears", got_m, 0);
  endtask

  task automatic t_disable;
    int cm, cb;
    set_cfg(1, 1'b1, 10);
    pulse(1);
    train(1, 3, cm, cb);           // residue 2
    set_cfg(1, 1'b0, 10);
    train(1, 4, cm, cb);
    chk("R2 disabled main", cm, 0);
    chk("R2 disabled bypass", cb, 0);
    set_cfg(1, 1'b1, 10);
    pulse(1); chk("R2 phase held 1", got_m, 0);
    pulse(1); chk("R2 phase held 2", got_m, 1);
  endtask

  task automatic t_small;
    int cm, cb;
    set_cfg(3, 1'b1, 2);
    pulse(3);
    train(3, 5, cm, cb);
    chk("R7 every strobe", cm, 5);
  endtask

  task automatic t_zero;
    int cm, cb;
    set_cfg(1, 1'b1, 0);
    train(1, 5, cm, cb);
    chk("R6 zero divisor silent", cm, 0);
    chk("R8 bypass ignores divisor", cb, 5);
  endtask

  task automatic t_select;
    set_cfg(2, 1'b1, U);
    pulse(2);
    pulse(1); chk("R1 unselected main", got_m, 0);
    chk("R1 unselected bypass", got_b, 0);
    pulse(3); chk("R1 unselected src3", got_m, 0);
    pulse(2); chk("R1 selected", got_m, 1);
    set_cfg(0, 1'b1, U);
    pulse(0); chk("R1 ground main", got_m, 0);
    pulse(0); chk("R1 ground bypass", got_b, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_busy();
    t_ratio(10, 20);
    t_ratio(U, 20);
    t_ratio(16, 20);
    t_ratio(63, 20);
    t_width();
    t_clear();
    t_disable();
    t_small();
    t_zero();
    t_select();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule